// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a parameterised set of up to 32 asynchronous interrupt lines from outside the chip. Each line is brought into the clock domain through a synchroniser. Each line is then checked against its own sense rule: a low level, a high level, a rising edge or a falling edge. A detected event sets a sticky per-line status bit. Software controls which lines may interrupt through a per-line mask. The mask has separate write-one-to-set and write-one-to-clear ports, so no read-modify-write is needed. A status bit is cleared by writing a one to its position.

One combined interrupt output rises whenever a status bit and its mask bit are both set. A separate control bit gates a non-maskable request input through to its own output. The sense rule for a line comes from three per-line vectors:

- a type vector chooses level or edge sensing;
- a polarity-for-edges vector chooses rising or falling;
- a polarity-for-levels vector chooses high or low.

Bits for lines that are not built always read zero. Software can therefore find the line count by writing all ones to the type vector and reading it back.

Every bus access is decoded into one of the named access kinds:

- ACC_NONE
- ACC_IER
- ACC_IDR
- ACC_IMR
- ACC_ISR
- ACC_ICR
- ACC_MODE
- ACC_EDGE
- ACC_LEVEL
- ACC_NMI

The decoded kind steers the register writes and the read multiplexer. The sense rule of each line is one of four named kinds:

- SENSE_FALL
- SENSE_RISE
- SENSE_LOW
- SENSE_HIGH

The sense kind is formed from the type bit and the selected polarity bit. There are no transitions: the decode is recomputed every cycle from the address.

Top module: `xint_ctrl`

## Requirements
- R1: Byte offsets are decoded as follows; any other address reads zero and a write to it changes nothing.
  - Mask-set: 0x00, write.
  - Mask-clear: 0x04, write.
  - Mask: 0x08, read.
  - Status: 0x0C, read.
  - Status-clear: 0x10, write.
  - Type: 0x14, read and write.
  - Edge polarity: 0x18, read and write.
  - Level polarity: 0x1C, read and write.
  - NMI control: 0x24, read and write.
- R2: A write to mask-set sets each mask bit whose data bit is one; mask bits whose data bit is zero keep their value.
- R3: A write to mask-clear clears each mask bit whose data bit is one; mask bits whose data bit is zero keep their value.
- R4: A write to status-clear clears each status bit whose data bit is one. If a line detects an event in the same cycle as the clear, the status bit ends up set.
- R5: Bits at or above NUM_LINES read zero in the type, edge-polarity, level-polarity and mask registers, whatever was written.
- R6: Edge sensing applies when type bit i is 0.
  - Edge-polarity bit i = 1 selects rising edges and 0 selects falling edges; the opposite edge sets nothing.
  - Status bit i becomes readable after the third rising clock edge following an input change.
  - Status bit i stays set until it is cleared.
- R7: Level sensing applies when type bit i is 1.
  - Level-polarity bit i = 1 means active-high and 0 means active-low.
  - Status bit i cannot be cleared while its line is active.
  - Status bit i stays set after the line goes inactive, until it is cleared.
- R8: irq_out is high exactly when some line has both its status bit and its mask bit set. Status is captured whether or not the line is masked.
- R9: Bit 0 of NMI control reads back as written, and the other bits of that register read zero. nmi_out equals nmi_req ANDed with that bit.
- R10: After reset, all of the following are zero: mask, status, type, edge polarity, level polarity and NMI control. With type 0 and edge polarity 0, every line is sensed on a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_lines | input | NUM_LINES | Asynchronous external interrupt lines |
| nmi_req | input | 1 | Non-maskable request source |
| irq_out | output | 1 | Combined masked interrupt |
| nmi_out | output | 1 | Gated non-maskable request |

## Verification
The bench targets a clear write that lands in the very cycle a falling edge is captured. A design where the clear beats the set would lose that event, and status would read zero. It holds a level-high line active while clearing it; a design that let the clear win would drop an interrupt that is still asserted. It measures edge latency to the exact cycle and applies the opposite edge to each edge-sensed line. A design with a missing synchroniser stage, or with the polarity decode swapped, would then set status one cycle early or on the wrong transition. It also writes all ones to the per-line registers and to unused addresses. A design that kept unbuilt bits, or aliased the undecoded offsets, would read back non-zero.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;

    localparam int unsigned REG_W = 32;

    // byte offsets of the register map
    localparam int unsigned OFF_IER   = 32'h00;
    localparam int unsigned OFF_IDR   = 32'h04;
    localparam int unsigned OFF_IMR   = 32'h08;
    localparam int unsigned OFF_ISR   = 32'h0C;
    localparam int unsigned OFF_ICR   = 32'h10;
    localparam int unsigned OFF_MODE  = 32'h14;
    localparam int unsigned OFF_EDGE  = 32'h18;
    localparam int unsigned OFF_LEVEL = 32'h1C;
    localparam int unsigned OFF_NMI   = 32'h24;

    // decoded register access
    typedef enum logic [3:0] {
        ACC_NONE  = 4'd0,
        ACC_IER   = 4'd1,
        ACC_IDR   = 4'd2,
        ACC_IMR   = 4'd3,
        ACC_ISR   = 4'd4,
        ACC_ICR   = 4'd5,
        ACC_MODE  = 4'd6,
        ACC_EDGE  = 4'd7,
        ACC_LEVEL = 4'd8,
        ACC_NMI   = 4'd9
    } xint_acc_e;

    // {type bit, polarity bit}
    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_HIGH = 2'b11
    } xint_sense_e;

    function automatic logic [REG_W-1:0] line_mask(input int unsigned n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < REG_W; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
module xint_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/xint_detect.sv
`timescale 1ns/1ps
module xint_detect
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_s,
    input  logic [NUM_LINES-1:0] mode_sel,
    input  logic [NUM_LINES-1:0] edge_pol,
    input  logic [NUM_LINES-1:0] level_pol,
    output logic [NUM_LINES-1:0] hit
);

    logic [NUM_LINES-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= line_s;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xint_sense_e sense;
        logic        hit_bit;

        assign sense = xint_sense_e'({mode_sel[i],
                                      mode_sel[i] ? level_pol[i] : edge_pol[i]});

        always_comb begin
            unique case (sense)
                SENSE_FALL: hit_bit = prev_q[i] & ~line_s[i];
                SENSE_RISE: hit_bit = ~prev_q[i] & line_s[i];
                SENSE_LOW:  hit_bit = ~line_s[i];
                SENSE_HIGH: hit_bit = line_s[i];
                default:    hit_bit = 1'b0;
            endcase
        end

        assign hit[i] = hit_bit;
    end

endmodule

// File: rtl/xint_regs.sv
`timescale 1ns/1ps
module xint_regs
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] hit,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] status_q,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] edge_q,
    output logic [NUM_LINES-1:0] level_q,
    output logic                 nmi_en_q
);

    localparam logic [ADDR_W-1:0] A_IER   = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] A_IDR   = ADDR_W'(OFF_IDR);
    localparam logic [ADDR_W-1:0] A_IMR   = ADDR_W'(OFF_IMR);
    localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFF_ISR);
    localparam logic [ADDR_W-1:0] A_ICR   = ADDR_W'(OFF_ICR);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(OFF_EDGE);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_NMI   = ADDR_W'(OFF_NMI);

    xint_acc_e            acc;
    logic [NUM_LINES-1:0] wd;
    logic [NUM_LINES-1:0] clr_vec;
    logic                 unused_wdata;

    assign wd           = bus_wdata[NUM_LINES-1:0];
    assign unused_wdata = ^bus_wdata;

    // address decode
    always_comb begin
        unique case (bus_addr)
            A_IER:   acc = ACC_IER;
            A_IDR:   acc = ACC_IDR;
            A_IMR:   acc = ACC_IMR;
            A_ISR:   acc = ACC_ISR;
            A_ICR:   acc = ACC_ICR;
            A_MODE:  acc = ACC_MODE;
            A_EDGE:  acc = ACC_EDGE;
            A_LEVEL: acc = ACC_LEVEL;
            A_NMI:   acc = ACC_NMI;
            default: acc = ACC_NONE;
        endcase
    end

    assign clr_vec = (bus_wr && acc == ACC_ICR) ? wd : '0;

    // configuration and mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            mode_q   <= '0;
            edge_q   <= '0;
            level_q  <= '0;
            nmi_en_q <= 1'b0;
        end else if (bus_wr) begin
            unique case (acc)
                ACC_IER:   mask_q   <= mask_q | wd;
                ACC_IDR:   mask_q   <= mask_q & ~wd;
                ACC_MODE:  mode_q   <= wd;
                ACC_EDGE:  edge_q   <= wd;
                ACC_LEVEL: level_q  <= wd;
                ACC_NMI:   nmi_en_q <= bus_wdata[0];
                default:   ;
            endcase
        end
    end

    // status capture: a new event beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= hit | (status_q & ~clr_vec);
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        unique case (acc)
            ACC_IMR:   bus_rdata[NUM_LINES-1:0] = mask_q;
            ACC_ISR:   bus_rdata[NUM_LINES-1:0] = status_q;
            ACC_MODE:  bus_rdata[NUM_LINES-1:0] = mode_q;
            ACC_EDGE:  bus_rdata[NUM_LINES-1:0] = edge_q;
            ACC_LEVEL: bus_rdata[NUM_LINES-1:0] = level_q;
            ACC_NMI:   bus_rdata[0]             = nmi_en_q;
            default:   bus_rdata                = '0;
        endcase
    end

endmodule

// File: rtl/xint_ctrl.sv
`timescale 1ns/1ps
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] ext_lines,
    input  logic                 nmi_req,
    output logic                 irq_out,
    output logic                 nmi_out
);

    logic [NUM_LINES-1:0] line_s;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] edge_q;
    logic [NUM_LINES-1:0] level_q;
    logic                 nmi_en_q;

    xint_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_lines),
        .dout  (line_s)
    );

    xint_detect #(
        .NUM_LINES (NUM_LINES)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .mode_sel  (mode_q),
        .edge_pol  (edge_q),
        .level_pol (level_q),
        .hit       (hit)
    );

    xint_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit       (hit),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .mode_q    (mode_q),
        .edge_q    (edge_q),
        .level_q   (level_q),
        .nmi_en_q  (nmi_en_q)
    );

    assign irq_out = |(status_q & mask_q);
    assign nmi_out = nmi_req & nmi_en_q;

endmodule

// File: rtl/xint_ctrl_chk.sv
`timescale 1ns/1ps
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] status,
    input logic                 irq_out
);

    localparam logic [ADDR_W-1:0] C_IER  = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] C_IDR  = ADDR_W'(OFF_IDR);
    localparam logic [ADDR_W-1:0] C_ICR  = ADDR_W'(OFF_ICR);
    localparam logic [ADDR_W-1:0] C_MODE = ADDR_W'(OFF_MODE);
    localparam logic [31:0]       LMASK  = line_mask(NUM_LINES);

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_IER)
        |=> ((mask & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_IDR)
        |=> ((mask & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R4 R6: a status bit only falls where a clear write named it
    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~status)
                  & ~($past(bus_wr && bus_addr == C_ICR) ? $past(bus_wdata[NUM_LINES-1:0])
                                                          : '0)) == '0));

    assert_mode_unbuilt_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == C_MODE) |-> ((bus_rdata & ~LMASK) == '0));

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_IDR && bus_wdata[NUM_LINES-1:0] == '1) |=> !irq_out);

endmodule

bind xint_ctrl xint_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask      (mask_q),
    .status    (status_q),
    .irq_out   (irq_out)
);

// File: tb/xint_ctrl_bench.sv
`timescale 1ns/1ps
module xint_ctrl_bench;

    localparam int unsigned NL = 8;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] ext_lines = '0;
    logic          nmi_req = 1'b0;
    logic          irq_out;
    logic          nmi_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xint_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .SYNC_STAGES(2)) u_xint_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_lines (ext_lines),
        .nmi_req   (nmi_req),
        .irq_out   (irq_out),
        .nmi_out   (nmi_out)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 16;
    localparam logic [75:0] VEC [NV] = '{
        {6'h00, 32'h0000_00A5, 6'h08, 32'h0000_00A5},  // R2
        {6'h00, 32'h0000_0010, 6'h08, 32'h0000_00B5},  // R2 zeros keep
        {6'h04, 32'h0000_0081, 6'h08, 32'h0000_0034},  // R3
        {6'h00, 32'hFFFF_FFFF, 6'h08, 32'h0000_00FF},  // R2 R5
        {6'h04, 32'hFFFF_FFFF, 6'h08, 32'h0000_0000},  // R3
        {6'h1C, 32'hFFFF_FFFF, 6'h1C, 32'h0000_00FF},  // R5
        {6'h14, 32'hFFFF_FFFF, 6'h14, 32'h0000_00FF},  // R5 line count
        {6'h14, 32'h0000_0000, 6'h14, 32'h0000_0000},  // R5
        {6'h1C, 32'h0000_0000, 6'h1C, 32'h0000_0000},  // R1
        {6'h18, 32'h0000_00F0, 6'h18, 32'h0000_00F0},  // R1
        {6'h18, 32'h0000_0000, 6'h18, 32'h0000_0000},  // R1
        {6'h24, 32'h0000_0003, 6'h24, 32'h0000_0001},  // R9
        {6'h24, 32'h0000_0000, 6'h24, 32'h0000_0000},  // R9
        {6'h2C, 32'hFFFF_FFFF, 6'h2C, 32'h0000_0000},  // R1 unused offset
        {6'h20, 32'hFFFF_FFFF, 6'h08, 32'h0000_0000},  // R1 no side effect
        {6'h10, 32'h0000_00FF, 6'h0C, 32'h0000_0000}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a,
                      input logic [31:0] bm, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata & bm, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd("R10 mask",   6'h08, 32'hFFFF_FFFF, 32'h0);
        rd("R10 status", 6'h0C, 32'hFFFF_FFFF, 32'h0);
        rd("R10 type",   6'h14, 32'hFFFF_FFFF, 32'h0);
        rd("R10 edge",   6'h18, 32'hFFFF_FFFF, 32'h0);
        rd("R10 level",  6'h1C, 32'hFFFF_FFFF, 32'h0);
        rd("R10 nmi",    6'h24, 32'hFFFF_FFFF, 32'h0);
        chk("R10 irq_out", {31'b0, irq_out}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][75:70], VEC[v][69:38]);
            rd($sformatf("vector %0d", v), VEC[v][37:32], 32'hFFFF_FFFF, VEC[v][31:0]);
        end

        // R6 falling edge on line 0, default sense
        @(negedge clk); ext_lines[0] = 1'b1;
        cyc(4);
        rd("R6 rising ignored in falling mode", 6'h0C, 32'h1, 32'h0);
        @(negedge clk); ext_lines[0] = 1'b0;
        cyc(2);
        rd("R6 latency not yet", 6'h0C, 32'h1, 32'h0);
        cyc(1);
        rd("R6 falling captured", 6'h0C, 32'h1, 32'h1);
        @(negedge clk); ext_lines[0] = 1'b1;
        cyc(4);
        rd("R6 edge status sticky", 6'h0C, 32'h1, 32'h1);
        chk("R8 masked line no irq", {31'b0, irq_out}, 32'h0);
        wr(6'h00, 32'h1);
        chk("R8 irq on unmask", {31'b0, irq_out}, 32'h1);
        wr(6'h10, 32'h1);
        rd("R4 clear status", 6'h0C, 32'h1, 32'h0);
        chk("R8 irq after clear", {31'b0, irq_out}, 32'h0);

        // R6 rising edge on line 1
        wr(6'h18, 32'h2);
        @(negedge clk); ext_lines[1] = 1'b1;
        cyc(2);
        rd("R6 rising latency", 6'h0C, 32'h2, 32'h0);
        cyc(1);
        rd("R6 rising captured", 6'h0C, 32'h2, 32'h2);
        wr(6'h10, 32'h2);
        @(negedge clk); ext_lines[1] = 1'b0;
        cyc(4);
        rd("R6 falling ignored in rising mode", 6'h0C, 32'h2, 32'h0);

        // R4 event and clear in the same cycle on line 2
        @(negedge clk); ext_lines[2] = 1'b1;
        cyc(4);
        @(negedge clk); ext_lines[2] = 1'b0;
        cyc(2);
        bus_addr  = 6'h10;
        bus_wdata = 32'h4;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        rd("R4 set wins over clear", 6'h0C, 32'h4, 32'h4);
        wr(6'h10, 32'h4);
        rd("R4 later clear", 6'h0C, 32'h4, 32'h0);

        // R7 level-high on line 3
        wr(6'h1C, 32'h8);
        wr(6'h14, 32'h8);
        rd("R7 inactive high level", 6'h0C, 32'h8, 32'h0);
        @(negedge clk); ext_lines[3] = 1'b1;
        cyc(3);
        rd("R7 active high captured", 6'h0C, 32'h8, 32'h8);
        wr(6'h10, 32'h8);
        rd("R7 clear blocked while active", 6'h0C, 32'h8, 32'h8);
        @(negedge clk); ext_lines[3] = 1'b0;
        cyc(3);
        rd("R7 sticky after release", 6'h0C, 32'h8, 32'h8);
        wr(6'h10, 32'h8);
        rd("R7 clear after release", 6'h0C, 32'h8, 32'h0);

        // R7 active-low on line 3 (line is low)
        wr(6'h1C, 32'h0);
        cyc(1);
        rd("R7 active low captured", 6'h0C, 32'h8, 32'h8);
        @(negedge clk); ext_lines[3] = 1'b1;
        cyc(3);
        wr(6'h10, 32'h8);
        rd("R7 low released cleared", 6'h0C, 32'h8, 32'h0);

        // R8 masked capture then unmask
        @(negedge clk); ext_lines[3] = 1'b0;
        cyc(3);
        rd("R8 status set while masked", 6'h0C, 32'h8, 32'h8);
        chk("R8 no irq, line masked", {31'b0, irq_out}, 32'h0);
        wr(6'h00, 32'h8);
        chk("R8 irq after unmask", {31'b0, irq_out}, 32'h1);
        wr(6'h04, 32'hFFFF_FFFF);
        chk("R3 irq after mask all", {31'b0, irq_out}, 32'h0);
        rd("R3 mask empty", 6'h08, 32'hFFFF_FFFF, 32'h0);

        // R9 NMI gating
        nmi_req = 1'b1;
        #1;
        chk("R9 nmi gated off", {31'b0, nmi_out}, 32'h0);
        wr(6'h24, 32'h1);
        chk("R9 nmi passed", {31'b0, nmi_out}, 32'h1);
        nmi_req = 1'b0;
        #1;
        chk("R9 nmi follows source", {31'b0, nmi_out}, 32'h0);
        wr(6'h24, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule